// File: doc/BRIEF.md
# Bit-Per-Line Reset Request and Settle-Status Controller

This block drives up to 32 active-low peripheral reset lines from one software-visible request word. Each request bit maps straight onto its reset line: a 0 holds the peripheral in reset and a 1 lets it run. Software sees completion in a second, read-only word. Each bit of that word follows its request bit only after a settle delay that is modelled per line. Software therefore changes the request word and then polls the status word until the bits it touched read back the new value.

A constant implemented-lines mask chooses which of the 32 positions exist. Positions outside the mask keep their line in reset, read as zero in both words and ignore writes. The default mask leaves out positions 0 to 2 and 28 to 31.

Each implemented line has its own two-state tracker:

- **SETTLED**: status equals request.
- **COUNTING**: a change is pending.

The transitions are:

- **SETTLED → COUNTING** when the request bit differs from the status bit.
- **COUNTING → SETTLED (complete)** on the settle-th mismatching edge. The status bit takes the request value on that edge.
- **COUNTING → SETTLED (cancel)** when the request returns to the status value before completion. The status bit is left untouched.

The default settle of 8 cycles at 200 MHz is 40 ns, well inside the 10 µs completion bound that the settle delay must respect.

Top module: `rstc_top`

## Requirements
- R1: The request word is at byte address 0x0 and the status word at 0x4. Any other address reads as 0. Read data is combinational from `addr`.
- R2: Only bits set in VALID_MASK (default 0x0FFFFFF8) are implemented. Other bits read 0 in both words, ignore writes, and hold their reset line at 0.
- R3: A write to 0x0 loads `wr_data & VALID_MASK` into the request word on that clock edge. From that edge `rst_n_o[i]` equals request bit i (0 = line in reset).
- R4: Each status bit takes its request bit's new value on the 8th rising edge (SETTLE_CYCLES) after the edge that changed the request bit. Status bit 1 means out of reset, 0 means in reset. Each line counts independently.
- R5: After reset the request word, the status word and all reset lines are 0, so every line starts in reset.
- R6: The status word is read-only. A write to 0x4, or to any address other than 0x0, changes neither word.
- R7: If a request bit returns to its status value before its settle count completes, the status bit never changes. A later change starts a fresh full count.
- R8: A request write that lands on the same edge as a line's settle completion takes effect on top of it. The status bit takes the earlier target on that edge. It then moves to the newer value SETTLE_CYCLES edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (4) | Byte address of the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the word at `addr` |
| rst_n_o | output | NUM_LINES (32) | Active-low reset lines, one per request bit |

## Verification
A line's settle completion and a fresh request write to the same line can fall in the same clock edge. The bench provokes this by writing a release, then writing the line back into reset exactly on the eighth edge after it. It judges the outcome by reading the status word just after that edge, where it must show the released value. It then reads again across the edge eight cycles later, where the status must return to reset. A second overlap is also judged: two writes four edges apart touching different lines. The status word must then step twice, on the edge that each line's own count completes.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    // Per-line settle tracker state.
    typedef enum logic {
        LANE_SETTLED  = 1'b0,
        LANE_COUNTING = 1'b1
    } lane_state_e;

    localparam int unsigned BUS_W = 32;
endpackage

// File: rtl/rstc_lane.sv
module rstc_lane
    import rstc_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic stat_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    lane_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic stat_q;
    logic differ;

    assign differ = (req_i != stat_q);
    assign stat_o = stat_q;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LANE_SETTLED:  if (differ) st_d = LANE_COUNTING;
            LANE_COUNTING: begin
                if (!differ)           st_d = LANE_SETTLED;   // cancel
                else if (cnt_q == LAST) st_d = LANE_SETTLED;  // complete
            end
            default: st_d = LANE_SETTLED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_SETTLED;
        else        st_q <= st_d;
    end

    // Counter and status output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            unique case (st_q)
                LANE_SETTLED: cnt_q <= differ ? CNT_W'(1) : '0;
                LANE_COUNTING: begin
                    if (!differ) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        stat_q <= req_i;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
    import rstc_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter logic [31:0] VALID_MASK = 32'h0FFF_FFF8,
    parameter int unsigned REQ_OFS    = 0,
    parameter int unsigned STAT_OFS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic [NUM_LINES-1:0] stat_i,
    output logic [NUM_LINES-1:0] req_o,
    output logic [BUS_W-1:0]     rd_data
);
    localparam logic [NUM_LINES-1:0] LMASK = VALID_MASK[NUM_LINES-1:0];

    logic [NUM_LINES-1:0] req_q;
    logic hit_req, hit_stat;

    assign hit_req  = (addr == ADDR_W'(REQ_OFS));
    assign hit_stat = (addr == ADDR_W'(STAT_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                req_q <= '0;
        else if (wr_en && hit_req) req_q <= wr_data[NUM_LINES-1:0] & LMASK;
    end

    assign req_o = req_q;

    always_comb begin
        rd_data = '0;
        if (hit_req)       rd_data[NUM_LINES-1:0] = req_q;
        else if (hit_stat) rd_data[NUM_LINES-1:0] = stat_i & LMASK;
    end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned NUM_LINES     = 32,
    parameter int unsigned ADDR_W        = 4,
    parameter logic [31:0] VALID_MASK    = 32'h0FFF_FFF8,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic [NUM_LINES-1:0] rst_n_o
);
    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] stat_q;

    rstc_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .VALID_MASK(VALID_MASK),
        .REQ_OFS   (0),
        .STAT_OFS  (4)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .stat_i (stat_q),
        .req_o  (req_q),
        .rd_data(rd_data)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (VALID_MASK[i]) begin : g_impl
            rstc_lane #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .req_i (req_q[i]),
                .stat_o(stat_q[i])
            );
        end else begin : g_absent
            assign stat_q[i] = 1'b0;
        end
    end

    assign rst_n_o = req_q;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter logic [31:0] VALID_MASK = 32'h0FFF_FFF8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          wr_data,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] rst_n_o,
    input logic [NUM_LINES-1:0] req_q,
    input logic [NUM_LINES-1:0] stat_q
);
    localparam logic [NUM_LINES-1:0] LMASK = VALID_MASK[NUM_LINES-1:0];

    // R1: unmapped addresses read zero
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADDR_W'(0) && addr != ADDR_W'(4)) |-> rd_data == 32'd0);

    // R2: absent positions stay zero on lines and status
    assert_absent_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_n_o & ~LMASK) == '0) && ((stat_q & ~LMASK) == '0));

    // R3: a write to the request word lands on the next edge and drives the lines
    assert_req_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=> rst_n_o == ($past(wr_data[NUM_LINES-1:0]) & LMASK));

    // R4: a status bit only moves where it differed from its request a cycle before
    assert_status_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q ^ $past(stat_q)) & ~($past(stat_q) ^ $past(req_q))) == '0);

    // R5: both words start cleared when reset releases
    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_q == '0 && stat_q == '0));

    // R6: writes elsewhere leave the request word alone
    assert_other_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_W'(0)) |=> $stable(req_q));
endmodule

bind rstc_top rstc_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .VALID_MASK(VALID_MASK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .rst_n_o(rst_n_o),
    .req_q  (req_q),
    .stat_q (stat_q)
);

// File: tb/sim_rstc_top.sv
`timescale 1ns/1ps
module sim_rstc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic [31:0] rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_line;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  smp_ev;

    localparam logic [31:0] MASK = 32'h0FFF_FFF8;

    always #2.5 clk = ~clk;

    rstc_top u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .rst_n_o(rst_n_o)
    );

    // Monitor: pops expectations and compares with the design's outputs
    initial begin
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_line ? rst_n_o : rd_data;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_line = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #0.5 -> smp_ev;
        #0.5;
    endtask

    task automatic exp_lines(input logic [31:0] e, input string tag);
        item_t it;
        it.is_line = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #0.5 -> smp_ev;
        #0.5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Called just after a write edge: status holds old up to edge 7, new after edge 8
    task automatic settle(input logic [31:0] old_v, input logic [31:0] new_v, input string tag);
        repeat (7) @(posedge clk);
        @(negedge clk); exp_rd(4'h4, old_v, {tag, " before settle"});
        @(negedge clk); exp_rd(4'h4, new_v, {tag, " after settle"});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R5: reset state
        @(negedge clk);
        exp_rd(4'h0, 32'd0, "R5 request after reset");
        exp_rd(4'h4, 32'd0, "R5 status after reset");
        exp_lines(32'd0, "R5 lines after reset");
        // R1: unmapped address
        exp_rd(4'h8, 32'd0, "R1 unmapped address 0x8");

        // R2/R3: write all ones, only masked bits take
        wr(4'h0, 32'hFFFF_FFFF);
        @(negedge clk);
        exp_rd(4'h0, MASK, "R2 request masked");
        exp_lines(MASK, "R3 lines follow request");
        settle(32'd0, MASK, "R4 release all");

        // R6: write to status word ignored
        wr(4'h4, 32'h0000_0000);
        @(negedge clk);
        exp_rd(4'h4, MASK, "R6 status unchanged by write");
        exp_rd(4'h0, MASK, "R6 request unchanged by status write");
        wr(4'hC, 32'h0);
        @(negedge clk);
        exp_rd(4'h0, MASK, "R6 request unchanged by unmapped write");

        // R3/R4: put line 5 into reset
        wr(4'h0, MASK & ~32'h20);
        @(negedge clk);
        exp_lines(MASK & ~32'h20, "R3 line 5 in reset");
        settle(MASK, MASK & ~32'h20, "R4 line 5 status");

        // R7: revert before completion
        wr(4'h0, MASK);
        repeat (2) @(posedge clk);
        wr(4'h0, MASK & ~32'h20);
        repeat (12) @(posedge clk);
        @(negedge clk);
        exp_rd(4'h4, MASK & ~32'h20, "R7 cancelled change leaves status");

        // R8: new write lands on the completion edge
        wr(4'h0, MASK);
        repeat (7) @(posedge clk);
        wr(4'h0, MASK & ~32'h20);
        @(negedge clk);
        exp_rd(4'h4, MASK, "R8 status took earlier target");
        exp_rd(4'h0, MASK & ~32'h20, "R8 request holds newer value");
        settle(MASK, MASK & ~32'h20, "R8 second settle");

        // R4: independent per-line counting
        wr(4'h0, 32'h0FFF_FF00);
        repeat (3) @(posedge clk);
        wr(4'h0, 32'h0FFF_0000);
        repeat (3) @(posedge clk);
        @(negedge clk); exp_rd(4'h4, MASK & ~32'h20, "R4 none settled yet");
        @(negedge clk); exp_rd(4'h4, 32'h0FFF_FF00, "R4 first group settled");
        repeat (3) @(posedge clk);
        @(negedge clk); exp_rd(4'h4, 32'h0FFF_FF00, "R4 second group pending");
        @(negedge clk); exp_rd(4'h4, 32'h0FFF_0000, "R4 second group settled");

        // R2: absent bits alone
        wr(4'h0, 32'hF000_0007);
        @(negedge clk);
        exp_lines(32'd0, "R2 absent bits ignored");
        settle(32'h0FFF_0000, 32'd0, "R4 all back in reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule